// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Override

This block controls a port of general-purpose pins from a small word-addressed register bus. Software sets each pin's direction, the value the pin should drive, and whether the pin acts as an open-drain output. Each of these three registers can be written whole, or changed through clear, set and invert aliases that touch only the bits written as 1, so one pin can change without a read-modify-write sequence.

Each pin can be taken over by an on-chip peripheral. While a pin's peripheral enable is high, the peripheral supplies the output data and the output enable in place of the register values. The pad input goes through a two-flop synchronizer. That synchronized value is what software reads from the port address, what peripherals receive, and what the change detector watches. A change on any monitored pin sets a sticky flag, and any set flag drives the interrupt line. Each pin also has its own weak pull-up enable, which goes straight to the pad.

Top module: `gpx_port`

## Requirements
- R1: After reset, every direction bit is 1 (input), so pad_oe is all 0. The output latch, open-drain, pull-up, change-enable and change-status registers all read 0, and irq is 0.
- R2: Register groups sit at word addresses 0 (direction), 4 (port), 8 (latch) and 12 (open-drain). Within a group, offset 0 writes the whole value, offset 1 clears the bits given as 1, offset 2 sets them and offset 3 inverts them. Bits written as 0 keep their value. A read at any of the four offsets returns the group's register.
- R3: A read of the port group returns the synchronized pad value, and a read of the latch group returns the stored latch. A write to the port group, through any alias, acts on the latch exactly as a latch write would.
- R4: A change on pad_in can be read at the port address after two rising clock edges. After only one edge, the port still reads the old value.
- R5: On a pin with no peripheral enable and no open-drain, pad_oe is the inverse of the direction bit and pad_out is the latch bit.
- R6: While alt_en of a pin is 1, pad_oe follows alt_oe and the output data follows alt_do, whatever the direction and latch hold. alt_in always presents the synchronized pad value.
- R7: While a pin's open-drain bit is 1, pad_od is 1 and pad_out is 0. pad_oe is 1 only when the selected output enable is 1 and the selected data is 0.
- R8: The weak pull-up register lives at address 17, and its bits appear on pad_pu.
- R9: The change-enable register lives at address 16 and the change-status register at address 18. A status bit is set when the synchronized value of an enabled pin begins to differ from its reference value. Pins that are not enabled never set a status bit. irq is the OR of all status bits.
- R10: A status bit stays set until software writes 1 to it at address 18, even while the pin still differs from its reference. A set caused by a new change takes priority over a clear in the same cycle. A read at address 4 loads the current synchronized value as the new reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Word address of the access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (a port read refreshes the change reference) |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data, combinational from bus_addr |
| pad_in | input | NPIN | Raw pad input levels |
| pad_out | output | NPIN | Output data to the pads |
| pad_oe | output | NPIN | Output driver enable per pad |
| pad_od | output | NPIN | Open-drain mode per pad |
| pad_pu | output | NPIN | Weak pull-up enable per pad |
| alt_en | input | NPIN | Peripheral owns the pin |
| alt_oe | input | NPIN | Output enable from the peripheral |
| alt_do | input | NPIN | Output data from the peripheral |
| alt_in | output | NPIN | Synchronized pad value for peripherals |
| irq | output | 1 | Change-notification interrupt |

## Verification
The latch is first loaded with a mixed pattern and then walked through each alias with masks that overlap set and cleared bits. This shows that the clear, set and invert aliases differ from a plain write and that untouched bits hold. The pad outputs are checked with GPIO mode, open-drain mode and peripheral override all active on neighbouring pins of one word, so a wrong priority in the output mux shows up as a single wrong bit. The change detector is driven with a toggle on an enabled pin, a toggle on a disabled pin, a clear while the difference persists, and a re-arm through a port read. Together these separate a level detector from an edge detector and a sticky flag from a transient one.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int ADDR_W = 5;

    // Alias operation selected by the two low address bits inside a group
    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_CLR = 2'd1,
        OP_SET = 2'd2,
        OP_INV = 2'd3
    } gpx_op_e;

    // Register group selected by address bits [3:2] when bit 4 is low
    typedef enum logic [1:0] {
        G_DIR  = 2'd0,
        G_PORT = 2'd1,
        G_LAT  = 2'd2,
        G_ODC  = 2'd3
    } gpx_grp_e;

    localparam logic [ADDR_W-1:0] A_CHGEN = 5'd16;
    localparam logic [ADDR_W-1:0] A_PULL  = 5'd17;
    localparam logic [ADDR_W-1:0] A_CHGST = 5'd18;

    typedef struct packed {
        logic     grouped;
        gpx_grp_e grp;
        gpx_op_e  op;
    } gpx_dec_t;

    function automatic gpx_dec_t gpx_decode(input logic [ADDR_W-1:0] a);
        gpx_dec_t d;
        d.grouped = ~a[4];
        d.grp     = gpx_grp_e'(a[3:2]);
        d.op      = gpx_op_e'(a[1:0]);
        return d;
    endfunction

endpackage

// File: rtl/gpx_alias_reg.sv
module gpx_alias_reg
    import gpx_pkg::*;
#(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  gpx_op_e      op,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (we) begin
            unique case (op)
                OP_WR:  q <= wd;
                OP_CLR: q <= q & ~wd;
                OP_SET: q <= q | wd;
                OP_INV: q <= q ^ wd;
            endcase
        end
    end

    // R2: clear alias leaves the masked bits at 0
    a_r2_clr_masked: assert property (@(posedge clk) disable iff (rst)
        (we && op == OP_CLR) |=> ((q & $past(wd)) == '0));
    // R2: set alias leaves the masked bits at 1
    a_r2_set_masked: assert property (@(posedge clk) disable iff (rst)
        (we && op == OP_SET) |=> ((q & $past(wd)) == $past(wd)));
    // R2: invert alias flips exactly the masked bits
    a_r2_inv_masked: assert property (@(posedge clk) disable iff (rst)
        (we && op == OP_INV) |=> ((q ^ $past(q)) == $past(wd)));
    // R2: an alias never touches bits written as 0
    a_r2_alias_keeps: assert property (@(posedge clk) disable iff (rst)
        (we && op != OP_WR) |=> (((q ^ $past(q)) & ~$past(wd)) == '0));
    // R2: no write, no change
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    // No reset: the pad level is sampled continuously
    always_ff @(posedge clk) begin
        meta_q <= d;
        q      <= meta_q;
    end

    // R4: each stage is exactly one edge behind the previous one
    a_r4_stage_one: assert property (@(posedge clk) disable iff (rst)
        meta_q == $past(d));
    a_r4_stage_two: assert property (@(posedge clk) disable iff (rst)
        q == $past(meta_q));

endmodule

// File: rtl/gpx_chg_detect.sv
module gpx_chg_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic [W-1:0] en,
    input  logic         ref_load,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);

    logic [W-1:0] ref_q;
    logic [W-1:0] diff_q;
    logic [W-1:0] diff;
    logic [W-1:0] new_evt;
    logic [W-1:0] clr_bits;

    assign diff     = din ^ ref_q;
    assign new_evt  = en & diff & ~diff_q;
    assign clr_bits = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            diff_q <= '0;
            status <= '0;
        end else begin
            if (ref_load) begin
                ref_q <= din;
            end
            diff_q <= diff;
            status <= (status & ~clr_bits) | new_evt;
        end
    end

    // R10: without a clear write no flag ever falls
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> (($past(status) & ~status) == '0));
    // R9: only enabled pins can raise a flag
    a_r9_enabled_only: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status) & ~$past(en)) == '0));

endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_od,
    output logic [NPIN-1:0]   pad_pu,
    input  logic [NPIN-1:0]   alt_en,
    input  logic [NPIN-1:0]   alt_oe,
    input  logic [NPIN-1:0]   alt_do,
    output logic [NPIN-1:0]   alt_in,
    output logic              irq
);

    localparam logic [NPIN-1:0] DIR_RST = '1;

    gpx_dec_t        dec;
    logic            wr_dir, wr_lat, wr_odc, wr_chg_clr, port_rd;
    logic [NPIN-1:0] dir_q, lat_q, odc_q, chgen_q, pull_q;
    logic [NPIN-1:0] pin_s, chg_st;

    assign dec        = gpx_decode(bus_addr);
    assign wr_dir     = bus_we && dec.grouped && (dec.grp == G_DIR);
    assign wr_lat     = bus_we && dec.grouped && (dec.grp == G_LAT || dec.grp == G_PORT);
    assign wr_odc     = bus_we && dec.grouped && (dec.grp == G_ODC);
    assign wr_chg_clr = bus_we && (bus_addr == A_CHGST);
    assign port_rd    = bus_re && dec.grouped && (dec.grp == G_PORT) && (dec.op == OP_WR);

    gpx_alias_reg #(.W(NPIN), .RST_VAL(DIR_RST)) u_dir (
        .clk(clk), .rst(rst), .we(wr_dir), .op(dec.op), .wd(bus_wdata), .q(dir_q));
    gpx_alias_reg #(.W(NPIN), .RST_VAL('0)) u_lat (
        .clk(clk), .rst(rst), .we(wr_lat), .op(dec.op), .wd(bus_wdata), .q(lat_q));
    gpx_alias_reg #(.W(NPIN), .RST_VAL('0)) u_odc (
        .clk(clk), .rst(rst), .we(wr_odc), .op(dec.op), .wd(bus_wdata), .q(odc_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            chgen_q <= '0;
            pull_q  <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_CHGEN) chgen_q <= bus_wdata;
            if (bus_addr == A_PULL)  pull_q  <= bus_wdata;
        end
    end

    gpx_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pin_s));

    gpx_chg_detect #(.W(NPIN)) u_chg (
        .clk(clk), .rst(rst), .din(pin_s), .en(chgen_q), .ref_load(port_rd),
        .clr_we(wr_chg_clr), .clr_mask(bus_wdata), .status(chg_st));

    always_comb begin
        bus_rdata = '0;
        if (dec.grouped) begin
            unique case (dec.grp)
                G_DIR:  bus_rdata = dir_q;
                G_PORT: bus_rdata = pin_s;
                G_LAT:  bus_rdata = lat_q;
                G_ODC:  bus_rdata = odc_q;
            endcase
        end else if (bus_addr == A_CHGEN) begin
            bus_rdata = chgen_q;
        end else if (bus_addr == A_PULL) begin
            bus_rdata = pull_q;
        end else if (bus_addr == A_CHGST) begin
            bus_rdata = chg_st;
        end
    end

    // Per-pin output multiplexer with open-drain emulation
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic oe_sel, do_sel;
        assign oe_sel     = alt_en[i] ? alt_oe[i] : ~dir_q[i];
        assign do_sel     = alt_en[i] ? alt_do[i] : lat_q[i];
        assign pad_oe[i]  = odc_q[i] ? (oe_sel & ~do_sel) : oe_sel;
        assign pad_out[i] = do_sel & ~odc_q[i];
    end

    assign pad_od = odc_q;
    assign pad_pu = pull_q;
    assign alt_in = pin_s;
    assign irq    = |chg_st;

    // R7: an open-drain pad never drives a high level
    a_r7_od_no_high: assert property (@(posedge clk) disable iff (rst)
        ((pad_od & pad_oe & pad_out) == '0));
    // R6: a peripheral-owned push-pull pin carries the peripheral data
    a_r6_alt_data: assert property (@(posedge clk) disable iff (rst)
        ((alt_en & ~pad_od & (pad_out ^ alt_do)) == '0));
    // R9: the interrupt follows the status register one-to-one
    a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == A_CHGST && bus_rdata == '0) |-> !irq);

endmodule

// File: tb/gpx_port_tb_top.sv
module gpx_port_tb_top;
    import gpx_pkg::*;

    localparam int N = 16;

    typedef struct {
        string       tag;
        logic [N-1:0] exp;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [N-1:0]      bus_wdata = '0;
    logic [N-1:0]      bus_rdata;
    logic [N-1:0]      pad_in = '0;
    logic [N-1:0]      pad_out, pad_oe, pad_od, pad_pu, alt_in;
    logic [N-1:0]      alt_en = '0, alt_oe = '0, alt_do = '0;
    logic              irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    item_t sb_q[$];

    always #10 clk = ~clk;

    gpx_port #(.NPIN(N)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu), .alt_en(alt_en),
        .alt_oe(alt_oe), .alt_do(alt_do), .alt_in(alt_in), .irq(irq));

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: register read, expected value goes to the scoreboard
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [N-1:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        bus_re   = 1'b1;
        it.tag = tag;
        it.exp = exp;
        sb_q.push_back(it);
        @(posedge clk);
        #1 bus_re = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compares read data mid-cycle against the scoreboard
    always begin
        @(negedge clk);
        #5;
        if (bus_re) begin
            if (sb_q.size() == 0) begin
                chk("scoreboard underflow", '0, '1);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(5'd0,  16'hFFFF, "R1 dir reset");
        rd(5'd8,  16'h0000, "R1 latch reset");
        rd(5'd12, 16'h0000, "R1 odc reset");
        rd(5'd16, 16'h0000, "R1 chgen reset");
        rd(5'd18, 16'h0000, "R1 status reset");
        @(negedge clk);
        chk("R1 pad_oe reset", pad_oe, 16'h0000);
        chk("R1 pad_pu reset", pad_pu, 16'h0000);
        chk("R1 irq reset", {15'd0, irq}, 16'h0000);

        // R2 alias operations on the latch
        wr(5'd8, 16'h00F0);  rd(5'd8,  16'h00F0, "R2 whole write");
        wr(5'd10, 16'h0003); rd(5'd8,  16'h00F3, "R2 set alias");
        wr(5'd9, 16'h0030);  rd(5'd8,  16'h00C3, "R2 clear alias");
        wr(5'd11, 16'h0101); rd(5'd8,  16'h01C2, "R2 invert alias");
        rd(5'd11, 16'h01C2, "R2 alias address read");

        // R3 port writes land in the latch
        wr(5'd4, 16'h1234);  rd(5'd8,  16'h1234, "R3 port write to latch");
        wr(5'd6, 16'h8000);  rd(5'd8,  16'h9234, "R3 port set alias");

        // R5 plain GPIO drive
        wr(5'd1, 16'h00FF);  rd(5'd0,  16'hFF00, "R2 dir clear alias");
        @(negedge clk);
        chk("R5 pad_oe", pad_oe, 16'h00FF);
        chk("R5 pad_out", pad_out, 16'h9234);

        // R4 synchronizer latency
        @(negedge clk);
        pad_in = 16'hA5A5;
        rd(5'd4, 16'h0000, "R4 one edge old");
        rd(5'd4, 16'hA5A5, "R4 two edges new");
        rd(5'd8, 16'h9234, "R3 latch not pin");

        // R7 open drain on bits 1 (data 0) and 2 (data 1)
        wr(5'd14, 16'h0006);
        @(negedge clk);
        chk("R7 pad_od", pad_od, 16'h0006);
        chk("R7 pad_oe", pad_oe, 16'h00FB);
        chk("R7 pad_out", pad_out, 16'h9230);

        // R6 peripheral override on bit 8 (an input in GPIO terms)
        alt_en = 16'h0100; alt_oe = 16'h0100; alt_do = 16'h0100;
        @(negedge clk);
        chk("R6 alt pad_oe", pad_oe, 16'h01FB);
        chk("R6 alt pad_out", pad_out, 16'h9330);
        chk("R6 alt_in", alt_in, 16'hA5A5);
        alt_oe = 16'h0000;
        @(negedge clk);
        chk("R6 alt oe off", pad_oe, 16'h00FB);
        alt_en = 16'h0000;
        @(negedge clk);
        chk("R6 release", pad_out, 16'h9230);

        // R8 pull-ups
        wr(5'd17, 16'h0F0F);
        @(negedge clk);
        chk("R8 pad_pu", pad_pu, 16'h0F0F);

        // R9 change notification
        wr(5'd16, 16'h0001);
        rd(5'd4, 16'hA5A5, "R9 arm reference");
        rd(5'd18, 16'h0000, "R9 no change yet");
        @(negedge clk);
        pad_in = 16'hA5A4;
        idle(4);
        chk("R9 irq on enabled change", {15'd0, irq}, 16'h0001);
        rd(5'd18, 16'h0001, "R9 status bit0");
        pad_in = 16'hA5A6;
        idle(4);
        rd(5'd18, 16'h0001, "R9 disabled pin ignored");

        // R10 sticky, write-one-clear, reference refresh
        idle(6);
        rd(5'd18, 16'h0001, "R10 flag held");
        wr(5'd18, 16'h0001);
        idle(3);
        rd(5'd18, 16'h0000, "R10 cleared with difference held");
        @(negedge clk);
        chk("R10 irq low", {15'd0, irq}, 16'h0000);
        rd(5'd4, 16'hA5A6, "R10 port read refresh");
        @(negedge clk);
        pad_in = 16'hA5A7;
        idle(4);
        rd(5'd18, 16'h0001, "R10 new edge after refresh");
        @(negedge clk);
        chk("R10 irq again", {15'd0, irq}, 16'h0001);

        idle(3);
        if (sb_q.size() != 0) chk("scoreboard drained", N'(sb_q.size()), '0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule